// File: doc/BRIEF.md
# Key Matrix Scan Sequencer

This block steps through the keys of a capacitive key matrix one at a time. The matrix has eight drive (X) lines and three receive (Y) lines. For each key it selects the X drive line and the Y receive line. It gives that key's burst length to an acquisition engine through a request/done handshake. It moves on only after the engine reports the burst complete. Keys that are switched off get no timeslot at all. A scan cycle therefore takes only as long as the enabled keys need. When the highest enabled key has finished, the block pulses an end-of-cycle flag and starts again from the lowest enabled key.

Per-key settings are held in two banks. The host writes a whole enable vector and a whole set of burst lengths in one atomic load, and that load goes into a pending bank. The pending bank is copied into the active bank only at the start of a scan cycle. A cycle in progress therefore always runs on one consistent configuration. The number of enabled keys is capped by a variant parameter, for example 16 for the smaller part. A load that asks for more keys than the cap is refused as a whole. After reset, only the lowest `MAX_KEYS` keys are enabled. On the 16-key variant these are the keys on Y0 and Y1.

Top module: `key_scan_seq`

## Requirements
- R1: Within a scan cycle, enabled keys are launched in strictly ascending key number, where key = y_sel*8 + x_sel. X advances fastest, so x_sel = key mod 8 and y_sel = key div 8.
- R2: A key whose bit in the active enable vector is 0 is never launched, and each enabled key is launched exactly once per scan cycle. `cfg_key_en` bit k enables key k.
- R3: `start_burst` stays high from launch until `burst_done` is sampled high. `key_idx`, `x_sel`, `y_sel` and `burst_len` stay constant over that interval. `start_burst` is low in the cycle after `burst_done` is accepted.
- R4: `burst_len` equals the active burst length of the launched key, taken from `cfg_burst_len[k*BL_W +: BL_W]`.
- R5: `scan_done` is a one-cycle pulse. It follows the completion of the highest enabled key and is never high together with `start_burst`.
- R6: A load whose enable vector has more than `MAX_KEYS` ones raises `cfg_rejected` for one cycle after the load. It leaves both banks unchanged.
- R7: After reset, keys 0 to `MAX_KEYS-1` are enabled, every burst length is `BL_RESET`, and `start_burst`, `scan_done` and `cfg_rejected` are low.
- R8: An accepted load becomes active only at the start of the next scan cycle. A load presented in the same cycle as the cycle start is first used in the cycle after that one.
- R9: With no key enabled, the block launches nothing and raises no `scan_done`. It resumes scanning once a load that enables keys has been committed.
- R10: A load with exactly `MAX_KEYS` enabled keys is accepted even when it includes Y2 keys, provided it disables others. The active enable count never exceeds `MAX_KEYS`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe for an atomic configuration load |
| cfg_key_en | input | NUM_KEYS | Enable bit per key (bit k is key k) |
| cfg_burst_len | input | NUM_KEYS*BL_W | Burst length per key, key k at [k*BL_W +: BL_W] |
| cfg_rejected | output | 1 | Pulse: the last load exceeded the key cap |
| start_burst | output | 1 | Burst request, held until done |
| burst_done | input | 1 | Acquisition engine reports burst complete |
| key_idx | output | KEY_W | Number of the key being acquired |
| x_sel | output | X_W | X drive line index |
| y_sel | output | Y_W | Y receive line index |
| burst_len | output | BL_W | Burst length for the current key |
| scan_done | output | 1 | Pulse at the end of each scan cycle |

## Verification
The case most likely to break is a configuration load that arrives in the same cycle the sequencer commits the pending bank at the start of a scan. The bench provokes it by asserting `cfg_load` at the very cycle in which `scan_done` is seen high; that is the commit cycle. It first loads a second configuration in the middle of a scan. It then requires the next scan to run on that earlier pending configuration, and the scan after it to run on the coincident load. Each scan is compared key by key against enable masks and burst lengths computed in the bench.

// File: rtl/key_scan_pkg.sv
package key_scan_pkg;

    typedef enum logic [1:0] {
        SEQ_START = 2'd0,
        SEQ_PICK  = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/key_scan_cfg.sv
module key_scan_cfg #(
    parameter int N        = 24,
    parameter int BW       = 8,
    parameter int MAX_KEYS = 16,
    parameter int BL_RESET = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [N-1:0]    en_i,
    input  logic [N*BW-1:0] bl_i,
    input  logic            commit_i,
    output logic [N-1:0]    act_en_o,
    output logic [N*BW-1:0] act_bl_o,
    output logic            reject_o
);

    function automatic logic [N-1:0] reset_mask();
        logic [N-1:0] m;
        for (int k = 0; k < N; k++) begin
            m[k] = (k < MAX_KEYS);
        end
        return m;
    endfunction

    localparam logic [N-1:0]    RST_EN = reset_mask();
    localparam logic [N*BW-1:0] RST_BL = {N{BW'(BL_RESET)}};

    typedef struct packed {
        logic [N-1:0]    pend_en;
        logic [N*BW-1:0] pend_bl;
        logic [N-1:0]    act_en;
        logic [N*BW-1:0] act_bl;
        logic            rej;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic    over_cap;

    assign over_cap = ($countones(en_i) > MAX_KEYS);

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.rej = 1'b0;
        if (commit_i) begin
            cfg_d.act_en = cfg_q.pend_en;
            cfg_d.act_bl = cfg_q.pend_bl;
        end
        if (load_i) begin
            if (over_cap) begin
                cfg_d.rej = 1'b1;
            end else begin
                cfg_d.pend_en = en_i;
                cfg_d.pend_bl = bl_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.pend_en <= RST_EN;
            cfg_q.pend_bl <= RST_BL;
            cfg_q.act_en  <= RST_EN;
            cfg_q.act_bl  <= RST_BL;
            cfg_q.rej     <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign act_en_o = cfg_q.act_en;
    assign act_bl_o = cfg_q.act_bl;
    assign reject_o = cfg_q.rej;

    // R6: an oversized load is refused and the pending bank is untouched
    a_r6_reject_oversize: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && over_cap) |=> (reject_o && $stable(cfg_q.pend_en) && $stable(cfg_q.pend_bl)));

    // R8: the active bank changes only on a commit
    a_r8_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(act_en_o) && $stable(act_bl_o)));

    // R10: the active enable count stays within the cap
    a_r10_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_en_o) <= MAX_KEYS);

endmodule

// File: rtl/key_scan_pick.sv
module key_scan_pick #(
    parameter int N     = 24,
    parameter int BW    = 8,
    parameter int NUM_X = 8,
    parameter int KW    = 5,
    parameter int XW    = 3,
    parameter int YW    = 2
) (
    input  logic [N-1:0]    mask_i,
    input  logic [N*BW-1:0] bl_i,
    input  logic [KW-1:0]   from_i,
    output logic            found_o,
    output logic [KW-1:0]   idx_o,
    output logic [XW-1:0]   x_o,
    output logic [YW-1:0]   y_o,
    output logic [BW-1:0]   bl_o
);

    // Lowest enabled key at or above from_i; the descending walk lets the lowest win.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        x_o     = '0;
        y_o     = '0;
        bl_o    = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (mask_i[k] && (k >= int'(from_i))) begin
                found_o = 1'b1;
                idx_o   = KW'(k);
                x_o     = XW'(k % NUM_X);
                y_o     = YW'(k / NUM_X);
                bl_o    = bl_i[k*BW +: BW];
            end
        end
    end

endmodule

// File: rtl/key_scan_ctrl.sv
module key_scan_ctrl
    import key_scan_pkg::*;
#(
    parameter int N     = 24,
    parameter int BW    = 8,
    parameter int NUM_X = 8,
    parameter int KW    = 5,
    parameter int XW    = 3,
    parameter int YW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_done_i,
    input  logic [N-1:0]  act_en_i,
    input  logic          pick_found_i,
    input  logic [KW-1:0] pick_idx_i,
    input  logic [XW-1:0] pick_x_i,
    input  logic [YW-1:0] pick_y_i,
    input  logic [BW-1:0] pick_bl_i,
    output logic          commit_o,
    output logic [KW-1:0] scan_from_o,
    output logic          req_o,
    output logic [KW-1:0] key_o,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o,
    output logic [BW-1:0] bl_o,
    output logic          done_o
);

    typedef struct packed {
        seq_state_e    state;
        logic [KW-1:0] idx;
        logic [KW-1:0] key;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic [BW-1:0] bl;
        logic          req;
        logic          done;
        logic          seen;
    } seq_st_t;

    seq_st_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            SEQ_START: begin
                seq_d.state = SEQ_PICK;
                seq_d.idx   = '0;
            end
            SEQ_PICK: begin
                if (pick_found_i) begin
                    seq_d.state = SEQ_WAIT;
                    seq_d.key   = pick_idx_i;
                    seq_d.x     = pick_x_i;
                    seq_d.y     = pick_y_i;
                    seq_d.bl    = pick_bl_i;
                    seq_d.req   = 1'b1;
                    seq_d.seen  = 1'b1;
                end else begin
                    seq_d.state = SEQ_START;
                    seq_d.done  = seq_q.seen;
                    seq_d.seen  = 1'b0;
                    seq_d.idx   = '0;
                end
            end
            SEQ_WAIT: begin
                if (burst_done_i) begin
                    seq_d.req   = 1'b0;
                    seq_d.idx   = seq_q.key + 1'b1;
                    seq_d.state = SEQ_PICK;
                end
            end
            default: seq_d.state = SEQ_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= SEQ_START;
            seq_q.idx   <= '0;
            seq_q.key   <= '0;
            seq_q.x     <= '0;
            seq_q.y     <= '0;
            seq_q.bl    <= '0;
            seq_q.req   <= 1'b0;
            seq_q.done  <= 1'b0;
            seq_q.seen  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign commit_o    = (seq_q.state == SEQ_START);
    assign scan_from_o = seq_q.idx;
    assign req_o       = seq_q.req;
    assign key_o       = seq_q.key;
    assign x_o         = seq_q.x;
    assign y_o         = seq_q.y;
    assign bl_o        = seq_q.bl;
    assign done_o      = seq_q.done;

    // R1: line selects agree with the key number
    a_r1_key_lines: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (int'(key_o) == int'(y_o) * NUM_X + int'(x_o)));

    // R2: only keys enabled in the active bank are launched
    a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> act_en_i[key_o]);

    // R3: request and its fields hold until done
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !burst_done_i) |=> (req_o && $stable(key_o) && $stable(x_o)
                                      && $stable(y_o) && $stable(bl_o)));

    // R3: request drops after the done is accepted
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && burst_done_i) |=> !req_o);

    // R5: end-of-cycle is a single pulse, never alongside a request
    a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_o);

    // R9: nothing is requested while the active bank is empty
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en_i == '0) |-> !req_o);

endmodule

// File: rtl/key_scan_seq.sv
module key_scan_seq #(
    parameter int NUM_X    = 8,
    parameter int NUM_Y    = 3,
    parameter int BL_W     = 8,
    parameter int MAX_KEYS = 16,
    parameter int BL_RESET = 16,
    localparam int NUM_KEYS = NUM_X * NUM_Y,
    localparam int KEY_W    = $clog2(NUM_KEYS + 1),
    localparam int X_W      = (NUM_X > 1) ? $clog2(NUM_X) : 1,
    localparam int Y_W      = (NUM_Y > 1) ? $clog2(NUM_Y) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_load,
    input  logic [NUM_KEYS-1:0]      cfg_key_en,
    input  logic [NUM_KEYS*BL_W-1:0] cfg_burst_len,
    output logic                     cfg_rejected,
    output logic                     start_burst,
    input  logic                     burst_done,
    output logic [KEY_W-1:0]         key_idx,
    output logic [X_W-1:0]           x_sel,
    output logic [Y_W-1:0]           y_sel,
    output logic [BL_W-1:0]          burst_len,
    output logic                     scan_done
);

    logic [NUM_KEYS-1:0]      act_en;
    logic [NUM_KEYS*BL_W-1:0] act_bl;
    logic                     commit;
    logic [KEY_W-1:0]         scan_from;
    logic                     pick_found;
    logic [KEY_W-1:0]         pick_idx;
    logic [X_W-1:0]           pick_x;
    logic [Y_W-1:0]           pick_y;
    logic [BL_W-1:0]          pick_bl;

    key_scan_cfg #(
        .N        (NUM_KEYS),
        .BW       (BL_W),
        .MAX_KEYS (MAX_KEYS),
        .BL_RESET (BL_RESET)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cfg_load),
        .en_i     (cfg_key_en),
        .bl_i     (cfg_burst_len),
        .commit_i (commit),
        .act_en_o (act_en),
        .act_bl_o (act_bl),
        .reject_o (cfg_rejected)
    );

    key_scan_pick #(
        .N     (NUM_KEYS),
        .BW    (BL_W),
        .NUM_X (NUM_X),
        .KW    (KEY_W),
        .XW    (X_W),
        .YW    (Y_W)
    ) u_pick (
        .mask_i  (act_en),
        .bl_i    (act_bl),
        .from_i  (scan_from),
        .found_o (pick_found),
        .idx_o   (pick_idx),
        .x_o     (pick_x),
        .y_o     (pick_y),
        .bl_o    (pick_bl)
    );

    key_scan_ctrl #(
        .N     (NUM_KEYS),
        .BW    (BL_W),
        .NUM_X (NUM_X),
        .KW    (KEY_W),
        .XW    (X_W),
        .YW    (Y_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_done_i (burst_done),
        .act_en_i     (act_en),
        .pick_found_i (pick_found),
        .pick_idx_i   (pick_idx),
        .pick_x_i     (pick_x),
        .pick_y_i     (pick_y),
        .pick_bl_i    (pick_bl),
        .commit_o     (commit),
        .scan_from_o  (scan_from),
        .req_o        (start_burst),
        .key_o        (key_idx),
        .x_o          (x_sel),
        .y_o          (y_sel),
        .bl_o         (burst_len),
        .done_o       (scan_done)
    );

endmodule

// File: tb/key_scan_seq_tb.sv
`timescale 1ns/1ps
module key_scan_seq_tb;

    localparam int NK   = 24;
    localparam int CAP  = 16;
    localparam int BLR  = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_load;
    logic [NK-1:0]  cfg_key_en;
    logic [NK*8-1:0] cfg_burst_len;
    logic           cfg_rejected;
    logic           start_burst;
    logic           burst_done;
    logic [4:0]     key_idx;
    logic [2:0]     x_sel;
    logic [1:0]     y_sel;
    logic [7:0]     burst_len;
    logic           scan_done;

    int n_cmp  = 0;
    int n_bad  = 0;
    int overlap = 0;
    int wait_cnt = 0;

    always #2.5 clk = ~clk;

    key_scan_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_load      (cfg_load),
        .cfg_key_en    (cfg_key_en),
        .cfg_burst_len (cfg_burst_len),
        .cfg_rejected  (cfg_rejected),
        .start_burst   (start_burst),
        .burst_done    (burst_done),
        .key_idx       (key_idx),
        .x_sel         (x_sel),
        .y_sel         (y_sel),
        .burst_len     (burst_len),
        .scan_done     (scan_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ones(input logic [NK-1:0] m);
        int c = 0;
        for (int k = 0; k < NK; k++) c += int'(m[k]);
        return c;
    endfunction

    function automatic int exp_bl(input int base, input int k);
        return (base < 0) ? BLR : ((base + 3 * k) % 256);
    endfunction

    // acquisition engine model: variable latency per key
    initial begin
        burst_done = 1'b0;
        forever begin
            @(negedge clk);
            if (burst_done) begin
                burst_done = 1'b0;
            end else if (start_burst) begin
                if (wait_cnt >= int'(key_idx) % 3) begin
                    burst_done = 1'b1;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && scan_done && start_burst) overlap++;
    end

    task automatic wait_done();
        do @(negedge clk); while (!scan_done);
    endtask

    task automatic do_load(input logic [NK-1:0] m, input int base);
        cfg_key_en = m;
        for (int k = 0; k < NK; k++) cfg_burst_len[k*8 +: 8] = 8'(base + 3 * k);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        chk(cfg_rejected == (ones(m) > CAP), (ones(m) > CAP) ? "R6" : "R10",
            int'(cfg_rejected), int'(ones(m) > CAP), "reject flag");
    endtask

    task automatic check_scan(input logic [NK-1:0] m, input int base, input bit nowait,
                              input int from_key, input string tag);
        int gk[32];
        int gx[32];
        int gy[32];
        int gb[32];
        int n = 0;
        int ei = 0;
        bit prev;
        bit stab = 1'b1;
        if (!nowait) wait_done();
        prev = start_burst;
        forever begin
            @(negedge clk);
            if (scan_done) break;
            if (start_burst && !prev) begin
                if (n < 32) begin
                    gk[n] = int'(key_idx); gx[n] = int'(x_sel);
                    gy[n] = int'(y_sel);   gb[n] = int'(burst_len);
                    n++;
                end
            end else if (start_burst && prev && n > 0) begin
                if (int'(key_idx) != gk[n-1] || int'(x_sel) != gx[n-1] ||
                    int'(y_sel) != gy[n-1] || int'(burst_len) != gb[n-1]) stab = 1'b0;
            end
            prev = start_burst;
        end
        for (int k = from_key; k < NK; k++) begin
            if (m[k]) begin
                if (ei < n) begin
                    chk(gk[ei] == k, "R1", gk[ei], k, {tag, " key order"});
                    chk(gx[ei] == k % 8 && gy[ei] == k / 8, "R1", gx[ei] + 8 * gy[ei], k, {tag, " x/y lines"});
                    chk(gb[ei] == exp_bl(base, k), "R4", gb[ei], exp_bl(base, k), {tag, " burst length"});
                end
                ei++;
            end
        end
        chk(n == ei, "R2", n, ei, {tag, " launch count"});
        chk(stab, "R3", int'(stab), 1, {tag, " fields held during burst"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int starts;
        int dones;
        rst_n = 1'b0;
        cfg_load = 1'b0;
        cfg_key_en = '0;
        cfg_burst_len = '0;
        repeat (4) @(negedge clk);
        chk(!start_burst, "R7", int'(start_burst), 0, "reset start_burst");
        chk(!scan_done, "R7", int'(scan_done), 0, "reset scan_done");
        chk(!cfg_rejected, "R7", int'(cfg_rejected), 0, "reset cfg_rejected");
        rst_n = 1'b1;

        // R7: reset configuration is keys 0..15 at the reset burst length
        check_scan(24'h00FFFF, -1, 1'b0, 0, "R7 reset");

        // sweep every single key
        for (int k = 0; k < NK; k++) begin
            do_load(24'h1 << k, 5 * k);
            check_scan(24'h1 << k, 5 * k, 1'b0, 0, "sweep");
        end

        do_load(24'h555555, 9);
        check_scan(24'h555555, 9, 1'b0, 0, "alternate");

        // R10: exactly at the cap, Y2 keys enabled with Y1 keys disabled
        do_load(24'hFF00FF, 10);
        check_scan(24'hFF00FF, 10, 1'b0, 0, "R10 cap");

        // R6: one over the cap is refused, previous setup stays
        do_load(24'h01FFFF, 20);
        check_scan(24'hFF00FF, 10, 1'b0, 0, "R6 after reject");

        // R8: load mid-scan, then a load coincident with the cycle start
        wait_done();
        do @(negedge clk); while (!start_burst);
        do_load(24'h0F0F0F, 40);
        check_scan(24'hFF00FF, 10, 1'b1, 1, "R8 current scan");
        do_load(24'hF0F0F0, 70);
        check_scan(24'h0F0F0F, 40, 1'b1, 0, "R8 coincident");
        check_scan(24'hF0F0F0, 70, 1'b1, 0, "R8 following");

        // R9: empty configuration idles, then resumes
        do_load(24'h000000, 0);
        wait_done();
        starts = 0;
        dones = 0;
        repeat (300) begin
            @(negedge clk);
            if (start_burst) starts++;
            if (scan_done) dones++;
        end
        chk(starts == 0, "R9", starts, 0, "idle launches");
        chk(dones == 0, "R9", dones, 0, "idle scan_done");
        do_load(24'h1 << 20, 90);
        check_scan(24'h1 << 20, 90, 1'b0, 0, "R9 resume");

        chk(overlap == 0, "R5", overlap, 0, "scan_done with start_burst");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule